// File: doc/BRIEF.md
# Vector Compress and Expand Unit

This block holds a small file of vector registers and performs three element-wise data-movement operations on it, one element per clock. A compress operation walks a source vector, packs its non-zero elements into one destination register and records where each came from in a second register. An expand operation does the reverse: it rebuilds a dense vector from a value register and an index register, with zeros wherever no index points. A masked copy moves source elements into a destination only at the positions where a control vector is non-zero.

The host selects an operation with an opcode, names the registers and the vector length, and pulses a start input. It then waits for a one-cycle done pulse. A load port writes single elements while the unit is idle. A combinational peek port reads any element back. The count of non-zero elements found by the last compress is always visible on an output, and the expand uses that count to decide how many entries to consume.

Top module: `vec_compress_unit`

## Requirements
- R1: After reset every element of every register reads zero, `count` is zero and `done` is low.
- R2: Compress (opcode 0) scans elements 0 to `vl`-1 of register `src_a`. It writes each non-zero element, in source order, into register `dst_a` starting at position 0, and sets `count` to the number of such elements. Positions at or above that number in `dst_a` keep their contents.
- R3: Compress writes the source position of each packed element, zero-extended, into register `dst_b` at the same packed position. Positions at or above `count` keep their contents.
- R4: Expand (opcode 1) clears positions 0 to `vl`-1 of register `dst_a`. Positions at or above `vl` keep their contents.
- R5: Expand reads entries 0 to `count`-1 and writes value `src_a[e]` into `dst_a` at the position given by `src_b[e]`. An entry whose index is `vl` or more is skipped.
- R6: When two expand entries name the same position, the entry with the higher entry number wins.
- R7: Masked copy (opcode 2) sets `dst_a[i]` to `src_a[i]` for each i below `vl` where `src_b[i]` is non-zero. Every other destination position keeps its contents.
- R8: Let N be `vl` for compress and masked copy, the current `count` for expand, and 0 for opcode 3. `done` goes high on the clock edge N edges after the edge that samples `start` (on that same edge when N is zero), and it stays high for exactly one cycle.
- R9: A `start` pulse that arrives while an operation is running is ignored. The running operation's latency and result are unchanged.
- R10: Opcode 3 writes nothing. Expand, masked copy and opcode 3 all leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 compress, 1 expand, 2 masked copy, 3 no-op |
| src_a | input | $clog2(NREG) | First source register |
| src_b | input | $clog2(NREG) | Second source register (indices or control) |
| dst_a | input | $clog2(NREG) | Destination register |
| dst_b | input | $clog2(NREG) | Index destination for compress |
| vl | input | $clog2(VL)+1 | Vector length, 0 to VL |
| done | output | 1 | One-cycle completion pulse |
| count | output | $clog2(VL)+1 | Non-zero count from the last compress |
| ld_en | input | 1 | Write one element (idle only) |
| ld_reg | input | $clog2(NREG) | Register to write |
| ld_idx | input | $clog2(VL) | Element to write |
| ld_data | input | DW | Data to write |
| peek_reg | input | $clog2(NREG) | Register to read |
| peek_idx | input | $clog2(VL) | Element to read |
| peek_data | output | DW | Element read back |

## Verification
The bench sweeps source patterns from all-zero to all-non-zero across lengths 0, 1, a partial length and the full length. A compress that mis-advanced its pack pointer would leave gaps or reorder data, and one with a wrong length bound would count elements past `vl`. Expands are checked against destinations preloaded with junk. A unit that skipped the clear, or cleared past `vl`, would show stale or missing data. Duplicate and out-of-range indices expose a wrong winner or a write outside the vector. A stray start in mid-operation, the no-op opcode and zero lengths show whether the unit restarts, writes when it should not, or stalls instead of finishing at once.

// File: rtl/vec_compress_unit.sv
module vec_compress_unit #(
  parameter int VL   = 128,
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [1:0]                op,
  input  logic [$clog2(NREG)-1:0]   src_a,
  input  logic [$clog2(NREG)-1:0]   src_b,
  input  logic [$clog2(NREG)-1:0]   dst_a,
  input  logic [$clog2(NREG)-1:0]   dst_b,
  input  logic [$clog2(VL):0]       vl,
  output logic                      done,
  output logic [$clog2(VL):0]       count,
  input  logic                      ld_en,
  input  logic [$clog2(NREG)-1:0]   ld_reg,
  input  logic [$clog2(VL)-1:0]     ld_idx,
  input  logic [DW-1:0]             ld_data,
  input  logic [$clog2(NREG)-1:0]   peek_reg,
  input  logic [$clog2(VL)-1:0]     peek_idx,
  output logic [DW-1:0]             peek_data
);
  localparam int IW = $clog2(VL);
  localparam int LW = IW + 1;
  localparam int RW = $clog2(NREG);
  localparam int CW = (DW > LW) ? DW : LW;
  localparam logic [1:0] OP_PACK = 2'd0, OP_EXP = 2'd1, OP_MASK = 2'd2;

  logic [DW-1:0] rf [NREG][VL];
  logic          busy_q, done_q;
  logic [1:0]    op_q;
  logic [RW-1:0] a_q, b_q, da_q, db_q;
  logic [LW-1:0] len_q, end_q, i_q, cnt_q;

  wire [LW-1:0] end_n = (op == OP_PACK || op == OP_MASK) ? vl :
                        (op == OP_EXP) ? cnt_q : '0;
  wire [DW-1:0] ea    = rf[a_q][i_q[IW-1:0]];
  wire [DW-1:0] eb    = rf[b_q][i_q[IW-1:0]];
  wire          last  = (i_q + 1'b1) == end_q;
  wire          in_rng = CW'(eb) < CW'(len_q);

  assign done      = done_q;
  assign count     = cnt_q;
  assign peek_data = rf[peek_reg][peek_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int j = 0; j < VL; j++)
          rf[r][j] <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      da_q   <= '0;
      db_q   <= '0;
      len_q  <= '0;
      end_q  <= '0;
      i_q    <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (ld_en) rf[ld_reg][ld_idx] <= ld_data;
        if (start) begin
          op_q  <= op;
          a_q   <= src_a;
          b_q   <= src_b;
          da_q  <= dst_a;
          db_q  <= dst_b;
          len_q <= vl;
          end_q <= end_n;
          i_q   <= '0;
          if (op == OP_PACK) cnt_q <= '0;
          if (op == OP_EXP)
            for (int j = 0; j < VL; j++)
              if (j < int'(vl)) rf[dst_a][j] <= '0;
          if (end_n == '0) done_q <= 1'b1;
          else             busy_q <= 1'b1;
        end
      end else begin
        case (op_q)
          OP_PACK: if (ea != '0) begin
            rf[da_q][cnt_q[IW-1:0]] <= ea;
            rf[db_q][cnt_q[IW-1:0]] <= DW'(i_q);
            cnt_q <= cnt_q + 1'b1;
          end
          OP_EXP:  if (in_rng) rf[da_q][eb[IW-1:0]] <= ea;
          OP_MASK: if (eb != '0) rf[da_q][i_q[IW-1:0]] <= ea;
          default: ;
        endcase
        i_q <= i_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && start && end_n == '0 |=> done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_q);
  // R9
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(op_q) && $stable(da_q) && $stable(len_q));
  // R2
  pack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && op_q == OP_PACK |-> cnt_q <= i_q);
  // R10
  cnt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && op_q != OP_PACK |=> $stable(cnt_q));
endmodule

// File: tb/vec_compress_unit_tb.sv
module vec_compress_unit_tb;
  localparam int VL = 16, DW = 8, NREG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ld_en = 1'b0;
  logic [1:0] op = '0, src_a = '0, src_b = '0, dst_a = '0, dst_b = '0;
  logic [1:0] ld_reg = '0, peek_reg = '0;
  logic [4:0] vl = '0;
  logic [3:0] ld_idx = '0, peek_idx = '0;
  logic [7:0] ld_data = '0;
  logic       done;
  logic [4:0] count;
  logic [7:0] peek_data;

  int checks = 0, fails = 0;
  int m [NREG][VL];
  int mcnt = 0;

  always #4 clk = ~clk;

  vec_compress_unit #(.VL(VL), .DW(DW), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .dst_a(dst_a), .dst_b(dst_b), .vl(vl),
    .done(done), .count(count),
    .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
    .peek_reg(peek_reg), .peek_idx(peek_idx), .peek_data(peek_data));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ld(int r, int i, int v);
    @(negedge clk);
    ld_en = 1'b1; ld_reg = 2'(r); ld_idx = 4'(i); ld_data = 8'(v);
    @(posedge clk);
    #1 ld_en = 1'b0;
    m[r][i] = v & 255;
  endtask

  task automatic cmp_all(string req_a, string req_b, int rb);
    for (int r = 0; r < NREG; r++)
      for (int i = 0; i < VL; i++) begin
        peek_reg = 2'(r); peek_idx = 4'(i);
        #1;
        chk((r == rb) ? req_b : req_a, int'(peek_data), m[r][i]);
      end
  endtask

  task automatic run(int o, int a, int b, int da, int db, int len, bit poke);
    int n, cyc, k, idx;
    n = (o == 0 || o == 2) ? len : (o == 1) ? mcnt : 0;
    @(negedge clk);
    start = 1'b1; op = 2'(o); src_a = 2'(a); src_b = 2'(b);
    dst_a = 2'(da); dst_b = 2'(db); vl = 5'(len);
    @(negedge clk);
    start = 1'b0; cyc = 0;
    while (!done && cyc < 400) begin
      if (poke && cyc == 2) begin start = 1'b1; op = 2'd2; vl = 5'd3; end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(poke ? "R9 latency" : "R8 latency", cyc, n);
    @(negedge clk);
    chk("R8 done one cycle", int'(done), 0);
    if (o == 0) begin
      k = 0;
      for (int i = 0; i < len; i++)
        if (m[a][i] != 0) begin m[da][k] = m[a][i]; m[db][k] = i; k++; end
      mcnt = k;
    end else if (o == 1) begin
      for (int j = 0; j < len; j++) m[da][j] = 0;
      for (int e = 0; e < mcnt; e++) begin
        idx = m[b][e];
        if (idx < len) m[da][idx] = m[a][e];
      end
    end else if (o == 2) begin
      for (int i = 0; i < len; i++) if (m[b][i] != 0) m[da][i] = m[a][i];
    end
    chk((o == 0) ? "R2 count" : "R10 count", int'(count), mcnt);
    case (o)
      0: cmp_all(poke ? "R9 data" : "R2", "R3", db);
      1: cmp_all("R4/R5", "R4/R5", 9);
      2: cmp_all("R7", "R7", 9);
      default: cmp_all("R10", "R10", 9);
    endcase
  endtask

  function automatic int pat(int p, int i);
    if (p == 0) return 0;
    if (p == 1) return i * 7 + 3;
    if (((i * (p + 3) + p) % 4) == 0) return 0;
    return (i * 7 + p + 1) & 255;
  endfunction

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lens [4] = '{0, 1, 7, 16};
    for (int r = 0; r < NREG; r++) for (int i = 0; i < VL; i++) m[r][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(count), 0);
    cmp_all("R1", "R1", 9);

    for (int p = 0; p < 6; p++)
      for (int li = 0; li < 4; li++) begin
        for (int i = 0; i < VL; i++) ld(0, i, pat(p, i));
        for (int i = 0; i < VL; i++) ld(3, i, 8'hA0 + i);
        run(0, 0, 0, 1, 2, lens[li], 1'b0);
        run(1, 1, 2, 3, 0, lens[li], 1'b0);
        for (int i = 0; i < VL; i++) ld(3, i, 8'h50 + i);
        run(2, 1, 0, 3, 0, lens[li], 1'b0);
      end

    // R6 duplicates, R5 out-of-range skip
    for (int i = 0; i < VL; i++) ld(0, i, i + 1);
    run(0, 0, 0, 1, 2, 6, 1'b0);
    ld(2, 0, 3); ld(2, 1, 3); ld(2, 2, 9); ld(2, 3, 1); ld(2, 4, 3); ld(2, 5, 12);
    for (int e = 0; e < 6; e++) ld(1, e, 11 + e);
    for (int i = 0; i < VL; i++) ld(3, i, 8'hC0 + i);
    run(1, 1, 2, 3, 0, 10, 1'b0);
    peek_reg = 2'd3; peek_idx = 4'd3; #1;
    chk("R6 last entry wins", int'(peek_data), 15);
    peek_idx = 4'd12; #1;
    chk("R5 out-of-range skipped", int'(peek_data), 8'hC0 + 12);

    // R9 start while busy
    for (int i = 0; i < VL; i++) ld(0, i, pat(3, i));
    run(0, 0, 0, 1, 2, 16, 1'b1);

    // R10 no-op opcode
    run(3, 0, 1, 2, 3, 5, 1'b0);
    run(3, 0, 1, 2, 3, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule